// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register-transfer datapath: four general registers share one common bus, and an address register points into a small internal memory. Each cycle, a source select picks the register that drives the bus. The bus is built as one multiplexer per bit position. Any set of destination registers can capture the bus word, or the memory word, on a clock edge.

Every transfer is guarded by a control-function input. On the edge that samples the control function high, the requested operation is registered as a pending command. The copy itself happens on the following edge. The source select is registered on every edge, so the bus always shows the register chosen one edge earlier.

Besides bus-to-register moves, the datapath offers four other operations. The address register can load from the bus. A memory read loads destinations from the word the address register points to. A memory write stores the bus word at that location. A memory write and a register load can run in the same cycle. Because the registers start cleared, the memory resets to a computed pattern, and that pattern is the only way data enters the datapath.

Top module: `rtx_bus_top`

## Requirements
- R1: While `rst` is high on a clock edge, all four registers, the address register and the pending command are cleared. Memory word k is set to (3*k + 5) mod 16.
- R2: `bus_o` equals the register whose index (0, 1, 2, 3 for the four registers) was on `src_sel` at the previous rising edge. Register i appears on `regs_o[4*i+3:4*i]`, and bit 0 is the least significant bit.
- R3: A transfer requested with `ctl_p` high at one rising edge is registered at that edge and changes the destination on the next rising edge, not earlier.
- R4: A request sampled with `ctl_p` low changes no register, no address register value and no memory word.
- R5: Every register whose bit in `ld_en` (bit i selects register i) was set takes the same word in the same transfer.
- R6: A register whose load bit is clear keeps its value through a transfer.
- R7: A transfer with `ar_ld` set loads the address register with the low 4 bits of the bus word.
- R8: A transfer with `mem_wr` set stores the bus word at the memory location given by the address register.
- R9: A transfer with `mem_rd` set loads the selected destinations from the memory word at the address register, instead of from the bus.
- R10: A memory write and a register load may happen in the same transfer. When `mem_rd` and `mem_wr` are both set, the destinations receive the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| src_sel | input | 2 | Index of the register that drives the bus |
| ld_en | input | 4 | Destination load lines, one per register |
| ar_ld | input | 1 | Load the address register from the bus |
| mem_rd | input | 1 | Destinations take the memory word rather than the bus |
| mem_wr | input | 1 | Store the bus word at the address register |
| ctl_p | input | 1 | Control function that gates the whole request |
| bus_o | output | 4 | Current common bus word |
| regs_o | output | 16 | The four registers, register i at bits 4*i+3 to 4*i |
| ar_o | output | 4 | Address register |

## Verification
The assertions check the following on every cycle:
- A low control function leaves no pending command.
- A register without a pending load holds its value.
- A loaded register takes the previous bus or memory word.
- The address register holds unless loaded.
- The memory changes only at the written address.

Some behaviours can only be shown by the bench's scenarios, because they involve the reset memory pattern, the values travelling over several transfers, or the order of a simultaneous read and write. Those scenarios are:
- The two-edge delay, seen at the ports between the two edges.
- Pointer bootstrapping through the address register.
- The read-before-write result.
- The bus showing each source in turn.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    localparam int unsigned RTX_DATA_W   = 4;
    localparam int unsigned RTX_NUM_REGS = 4;
    localparam int unsigned RTX_ADDR_W   = 4;
    localparam int unsigned RTX_INIT_MUL = 3;
    localparam int unsigned RTX_INIT_OFF = 5;

    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rtx_ctl.sv
module rtx_ctl #(
    parameter int unsigned NUM_REGS = rtx_pkg::RTX_NUM_REGS,
    parameter int unsigned SEL_W    = rtx_pkg::sel_width(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_p,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic [NUM_REGS-1:0] ld_en,
    input  logic                ar_ld,
    input  logic                mem_rd,
    input  logic                mem_wr,
    output logic [SEL_W-1:0]    src_q,
    output logic [NUM_REGS-1:0] ld_q,
    output logic                ar_ld_q,
    output logic                rd_q,
    output logic                wr_q
);

    typedef struct packed {
        logic [SEL_W-1:0]    src;
        logic [NUM_REGS-1:0] ld;
        logic                ar_ld;
        logic                rd;
        logic                wr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d       = '0;
        cmd_d.src   = src_sel;
        if (ctl_p) begin
            cmd_d.ld    = ld_en;
            cmd_d.ar_ld = ar_ld;
            cmd_d.rd    = mem_rd;
            cmd_d.wr    = mem_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assign src_q   = cmd_q.src;
    assign ld_q    = cmd_q.ld;
    assign ar_ld_q = cmd_q.ar_ld;
    assign rd_q    = cmd_q.rd;
    assign wr_q    = cmd_q.wr;

    // R4
    gate_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_p |=> (ld_q == '0 && !ar_ld_q && !rd_q && !wr_q));

    // R3
    gate_high_stage_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_p |=> (ld_q == $past(ld_en) && wr_q == $past(mem_wr)));

endmodule

// File: rtl/rtx_bus_mux.sv
module rtx_bus_mux #(
    parameter int unsigned NUM_REGS = rtx_pkg::RTX_NUM_REGS,
    parameter int unsigned DATA_W   = rtx_pkg::RTX_DATA_W,
    parameter int unsigned SEL_W    = rtx_pkg::sel_width(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [SEL_W-1:0]                sel_i,
    output logic [DATA_W-1:0]               bus_o
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [NUM_REGS-1:0] column;
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_src
            assign column[r] = regs_i[r][b];
        end
        assign bus_o[b] = column[sel_i];
    end

endmodule

// File: rtl/rtx_mem.sv
module rtx_mem #(
    parameter int unsigned DATA_W   = rtx_pkg::RTX_DATA_W,
    parameter int unsigned ADDR_W   = rtx_pkg::RTX_ADDR_W,
    parameter int unsigned INIT_MUL = rtx_pkg::RTX_INIT_MUL,
    parameter int unsigned INIT_OFF = rtx_pkg::RTX_INIT_OFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef logic [DEPTH-1:0][DATA_W-1:0] words_t;

    typedef struct packed {
        words_t words;
    } mem_st_t;

    mem_st_t st_d, st_q;

    function automatic words_t init_words();
        words_t w;
        for (int k = 0; k < DEPTH; k++) begin
            w[k] = DATA_W'(k * INIT_MUL + INIT_OFF);
        end
        return w;
    endfunction

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.words[addr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.words <= init_words();
        else     st_q       <= st_d;
    end

    assign rdata_o = st_q.words[addr_i];

    // R8
    mem_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (st_q.words[$past(addr_i)] == $past(wdata_i)));

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(st_q.words));

endmodule

// File: rtl/rtx_bus_top.sv
module rtx_bus_top #(
    parameter int unsigned NUM_REGS = rtx_pkg::RTX_NUM_REGS,
    parameter int unsigned DATA_W   = rtx_pkg::RTX_DATA_W,
    parameter int unsigned ADDR_W   = rtx_pkg::RTX_ADDR_W,
    parameter int unsigned SEL_W    = rtx_pkg::sel_width(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SEL_W-1:0]           src_sel,
    input  logic [NUM_REGS-1:0]        ld_en,
    input  logic                       ar_ld,
    input  logic                       mem_rd,
    input  logic                       mem_wr,
    input  logic                       ctl_p,
    output logic [DATA_W-1:0]          bus_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic [ADDR_W-1:0]          ar_o
);

    if (ADDR_W > DATA_W) begin : g_bad_width
        $error("address register is wider than the bus");
    end

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [ADDR_W-1:0]               ar;
    } dp_st_t;

    dp_st_t st_d, st_q;

    logic [SEL_W-1:0]    src_q;
    logic [NUM_REGS-1:0] ld_q;
    logic                ar_ld_q;
    logic                rd_q;
    logic                wr_q;
    logic [DATA_W-1:0]   bus;
    logic [DATA_W-1:0]   mem_word;

    rtx_ctl #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .ctl_p   (ctl_p),
        .src_sel (src_sel),
        .ld_en   (ld_en),
        .ar_ld   (ar_ld),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .src_q   (src_q),
        .ld_q    (ld_q),
        .ar_ld_q (ar_ld_q),
        .rd_q    (rd_q),
        .wr_q    (wr_q)
    );

    rtx_bus_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W)
    ) mux_i (
        .regs_i (st_q.regs),
        .sel_i  (src_q),
        .bus_o  (bus)
    );

    rtx_mem #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .INIT_MUL (rtx_pkg::RTX_INIT_MUL),
        .INIT_OFF (rtx_pkg::RTX_INIT_OFF)
    ) mem_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_q),
        .addr_i  (st_q.ar),
        .wdata_i (bus),
        .rdata_o (mem_word)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ld_q[i]) st_d.regs[i] = rd_q ? mem_word : bus;
        end
        if (ar_ld_q) st_d.ar = bus[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_o  = bus;
    assign regs_o = st_q.regs;
    assign ar_o   = st_q.ar;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_chk
        // R6
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !ld_q[i] |=> $stable(st_q.regs[i]));

        // R5
        reg_bus_load_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_q[i] && !rd_q) |=> (st_q.regs[i] == $past(bus)));

        // R9
        reg_mem_load_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_q[i] && rd_q) |=> (st_q.regs[i] == $past(mem_word)));
    end

    // R7
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ar_ld_q |=> $stable(st_q.ar));

endmodule

// File: tb/rtx_bus_top_tb_top.sv
`timescale 1ns/1ps
module rtx_bus_top_tb_top;

    localparam int NR = 4;
    localparam int DW = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    src_sel;
    logic [NR-1:0] ld_en;
    logic          ar_ld, mem_rd, mem_wr, ctl_p;
    logic [DW-1:0] bus_o;
    logic [NR*DW-1:0] regs_o;
    logic [AW-1:0] ar_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0] m_regs [NR];
    logic [AW-1:0] m_ar;
    logic [DW-1:0] m_mem [1<<AW];

    always #4 clk = ~clk;

    rtx_bus_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .ld_en   (ld_en),
        .ar_ld   (ar_ld),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .ctl_p   (ctl_p),
        .bus_o   (bus_o),
        .regs_o  (regs_o),
        .ar_o    (ar_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] reg_of(input int i);
        return regs_o[i*DW +: DW];
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < NR; i++) chk(req, reg_of(i), m_regs[i]);
        chk(req, ar_o, m_ar);
    endtask

    // One gated request: drive, first edge registers it, second edge performs it.
    task automatic issue(input string req, input int src, input logic [NR-1:0] ld,
                         input logic arl, input logic rd, input logic wr, input logic p);
        logic [DW-1:0] bus_v, rd_v;
        @(negedge clk);
        src_sel = 2'(src); ld_en = ld; ar_ld = arl; mem_rd = rd; mem_wr = wr; ctl_p = p;
        @(posedge clk);
        @(negedge clk);
        ld_en = '0; ar_ld = 0; mem_rd = 0; mem_wr = 0; ctl_p = 0;
        // R3: nothing moved yet after the first edge
        check_all({req, "/R3"});
        bus_v = m_regs[src];
        rd_v  = m_mem[m_ar];
        if (p) begin
            for (int i = 0; i < NR; i++) if (ld[i]) m_regs[i] = rd ? rd_v : bus_v;
            if (wr) m_mem[m_ar] = bus_v;
            if (arl) m_ar = bus_v[AW-1:0];
        end
        @(posedge clk);
        @(negedge clk);
        check_all(req);
        chk({req, "/R2"}, bus_o, m_regs[src]);
    endtask

    task automatic t_reset();
        rst = 1; src_sel = 0; ld_en = 0; ar_ld = 0; mem_rd = 0; mem_wr = 0; ctl_p = 0;
        for (int i = 0; i < NR; i++) m_regs[i] = '0;
        m_ar = '0;
        for (int k = 0; k < (1<<AW); k++) m_mem[k] = DW'(3*k + 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");
        chk("R1 bus", bus_o, 0);
    endtask

    task automatic t_bootstrap();
        issue("R9 read mem0 to reg0", 0, 4'b0001, 0, 1, 0, 1);   // reg0 = 5
        issue("R7 ar from reg0", 0, 4'b0000, 1, 0, 0, 1);        // ar = 5
        issue("R5 R9 read to reg1 reg2", 0, 4'b0110, 0, 1, 0, 1); // both = 4
    endtask

    task automatic t_gated_off();
        issue("R4 gate low", 0, 4'b1000, 1, 0, 1, 0);
        issue("R4 mem untouched", 0, 4'b1000, 0, 1, 0, 1);       // reg3 = mem5 = 4
    endtask

    task automatic t_bus_move();
        issue("R6 move reg1 to reg3 only", 1, 4'b1000, 0, 0, 0, 1);
        issue("R2 reg0 onto bus no load", 0, 4'b0000, 0, 0, 0, 1);
    endtask

    task automatic t_write();
        issue("R10 write plus load", 0, 4'b0100, 0, 0, 1, 1);    // mem5 = 5, reg2 = 5
        issue("R8 read back", 0, 4'b1000, 0, 1, 0, 1);           // reg3 = 5
    endtask

    task automatic t_read_write();
        issue("R10 read before write", 1, 4'b0001, 0, 1, 1, 1);  // reg0 = 5, mem5 = 4
        issue("R10 new word", 0, 4'b0100, 0, 1, 0, 1);           // reg2 = 4
    endtask

    task automatic t_broadcast();
        issue("R7 ar from reg2", 2, 4'b0000, 1, 0, 0, 1);        // ar = 4
        issue("R9 read mem4", 0, 4'b0010, 0, 1, 0, 1);           // reg1 = 1
        issue("R5 broadcast reg1", 1, 4'b1111, 0, 0, 0, 1);
        issue("R9 read mem4 to reg3", 0, 4'b1000, 0, 1, 0, 1);
    endtask

    task automatic t_bus_sweep();
        issue("R7 ar from reg0", 0, 4'b0000, 1, 0, 0, 1);        // ar = 1
        issue("R9 read mem1 to reg2", 0, 4'b0100, 0, 1, 0, 1);   // reg2 = 8
        for (int s = 0; s < NR; s++) issue("R2 sweep", s, 4'b0000, 0, 0, 0, 1);
    endtask

    initial begin
        t_reset();
        t_bootstrap();
        t_gated_off();
        t_bus_move();
        t_write();
        t_read_write();
        t_broadcast();
        t_bus_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule